// File: doc/BRIEF.md
# Dual-Channel Step Limiter

This block removes isolated spikes from a stream of paired acceleration samples. Each time a new X/Y pair arrives with its valid strobe, every channel measures how far its new sample lies from the previous raw sample of that same channel. A small step is passed through to the filtered output. A step at or beyond the threshold is withheld, and that channel's output keeps the value it already had.

The raw reference is refreshed on every valid sample, whether or not the sample was passed. A single outlier is therefore suppressed exactly once. A genuine level change that persists is accepted on the following sample. The two channels share the strobe and the output pulse but are otherwise fully separate. The sample width, the threshold and the signed or unsigned reading of the samples are parameters.

Top module: `spike_limiter`

## Requirements
- R1: While reset is asserted and after its release, before any valid input, `valid_o` is 0 and both filtered outputs are 0.
- R2: `valid_o` is 1 in exactly the cycle after each cycle in which `valid_i` is 1, and 0 otherwise.
- R3: The first valid pair after reset is copied to both outputs whatever its value, and it becomes the raw reference of each channel.
- R4: When the absolute difference between a channel's new sample and its previous raw sample is less than THRESH (default 0x80), that channel's output takes the new sample.
- R5: A difference exactly equal to THRESH is rejected, and the output keeps its prior value.
- R6: A difference greater than THRESH is rejected, and the output keeps its prior value.
- R7: The raw reference is loaded on every valid sample, including rejected ones. A repeated out-of-range value is therefore accepted on its second arrival.
- R8: The X and Y channels decide independently. In the same sample, one channel may accept while the other rejects.
- R9: With MODE = SAMPLE_SIGNED (the default), samples are read as two's complement. 0xFF6 to 0x00A is a step of 20, and 0x7FF to 0x800 is a step of 4095.
- R10: Without `valid_i`, the outputs hold their values even when the sample inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | New sample pair present |
| x_i | input | DATA_W | X channel raw sample |
| y_i | input | DATA_W | Y channel raw sample |
| valid_o | output | 1 | Filtered pair updated this cycle |
| x_o | output | DATA_W | X channel filtered value |
| y_o | output | DATA_W | Y channel filtered value |

## Verification
The bench builds the block with its defaults: 12-bit samples, a threshold of 0x80 and signed samples. The threshold is small enough that steps of 0x7F, 0x80 and 0x1FF land on both sides of the boundary with simple values. The 12-bit signed range makes the wrap between 0x7FF and 0x800 reachable, where an unsigned reading would give the opposite verdict. This wrap point, together with the pair 0xFF6/0x00A, checks that the difference is taken with the extra bit and with sign extension.

// File: rtl/spike_pkg.sv
package spike_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic {
    SAMPLE_UNSIGNED = 1'b0,
    SAMPLE_SIGNED   = 1'b1
  } sample_mode_e;
endpackage

// File: rtl/spike_absdiff.sv
module spike_absdiff
  import spike_pkg::*;
#(
  parameter int           DATA_W = 12,
  parameter sample_mode_e MODE   = SAMPLE_SIGNED
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W:0]   mag_o
);
  logic [DATA_W:0] a_ext, b_ext, diff;

  generate
    if (MODE == SAMPLE_SIGNED) begin : g_sext
      assign a_ext = {a_i[DATA_W-1], a_i};
      assign b_ext = {b_i[DATA_W-1], b_i};
    end else begin : g_zext
      assign a_ext = {1'b0, a_i};
      assign b_ext = {1'b0, b_i};
    end
  endgenerate

  // one guard bit: difference of two W-bit values always fits W+1 bits
  assign diff  = a_ext - b_ext;
  assign mag_o = diff[DATA_W] ? (~diff + 1'b1) : diff;
endmodule

// File: rtl/spike_chan.sv
module spike_chan
  import spike_pkg::*;
#(
  parameter int           DATA_W = 12,
  parameter int           THRESH = 128,
  parameter sample_mode_e MODE   = SAMPLE_SIGNED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              seed_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] filt_o
);
  localparam logic [DATA_W:0] THR_V = (DATA_W+1)'(THRESH);

  logic [DATA_W-1:0] prev_q, filt_q;
  logic [DATA_W:0]   mag;
  logic              accept;

  spike_absdiff #(.DATA_W(DATA_W), .MODE(MODE)) u_absdiff (
    .a_i   (sample_i),
    .b_i   (prev_q),
    .mag_o (mag)
  );

  assign accept = seed_i || (mag < THR_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      filt_q <= '0;
    end else if (load_i) begin
      prev_q <= sample_i;  // reference follows every sample
      if (accept) filt_q <= sample_i;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/spike_limiter.sv
module spike_limiter
  import spike_pkg::*;
#(
  parameter int           DATA_W = 12,
  parameter int           THRESH = 128,
  parameter sample_mode_e MODE   = SAMPLE_SIGNED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] x_o,
  output logic [DATA_W-1:0] y_o
);
  logic [NUM_CH-1:0][DATA_W-1:0] raw, filt;
  logic seeded_q, valid_q;

  assign raw[0] = x_i;
  assign raw[1] = y_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seeded_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) seeded_q <= 1'b1;
    end
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      spike_chan #(.DATA_W(DATA_W), .THRESH(THRESH), .MODE(MODE)) u_chan (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (valid_i),
        .seed_i   (!seeded_q),
        .sample_i (raw[c]),
        .filt_o   (filt[c])
      );
    end
  endgenerate

  assign valid_o = valid_q;
  assign x_o     = filt[0];
  assign y_o     = filt[1];
endmodule

// File: rtl/spike_limiter_chk.sv
module spike_limiter_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] x_i,
  input logic [DATA_W-1:0] y_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] x_o,
  input logic [DATA_W-1:0] y_o
);
  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(x_o) && $stable(y_o)));

  // an output may only change to the sample just presented
  assert_x_from_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (x_o == $past(x_o) || x_o == $past(x_i)));

  assert_y_from_sample_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (y_o == $past(y_o) || y_o == $past(y_i)));
endmodule

bind spike_limiter spike_limiter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .x_i     (x_i),
  .y_i     (y_i),
  .valid_o (valid_o),
  .x_o     (x_o),
  .y_o     (y_o)
);

// File: tb/tb_spike_limiter.sv
`timescale 1ns/1ps
module tb_spike_limiter;
  localparam int W = 12;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] x_i = '0, y_i = '0;
  logic         valid_o;
  logic [W-1:0] x_o, y_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  spike_limiter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .x_i(x_i), .y_i(y_i), .valid_o(valid_o), .x_o(x_o), .y_o(y_o)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // present one pair, then check outputs one edge later and the pulse end
  task automatic send(string req, logic [W-1:0] x, logic [W-1:0] y,
                      logic [W-1:0] ex, logic [W-1:0] ey);
    @(negedge clk_i);
    x_i = x; y_i = y; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " valid_o high R2"}, valid_o, 1);
    chk({req, " x"}, x_o, ex);
    chk({req, " y"}, y_o, ey);
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", valid_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid", valid_o, 0);
    chk("R1 x", x_o, 0);
    chk("R1 y", y_o, 0);
  endtask

  task automatic t_seed();
    send("R3 seed", 12'h500, 12'hA00, 12'h500, 12'hA00);
    @(negedge clk_i);
    chk("R2 pulse ends", valid_o, 0);
  endtask

  task automatic t_steps();
    send("R4 below thresh", 12'h57F, 12'hA10, 12'h57F, 12'hA10);
    send("R5 equal thresh", 12'h5FF, 12'hA10, 12'h57F, 12'hA10);
    send("R6 above thresh", 12'h400, 12'hA10, 12'h57F, 12'hA10);
    send("R7 persist accepted", 12'h400, 12'hA10, 12'h400, 12'hA10);
    send("R8 x ok y rejected", 12'h410, 12'h300, 12'h410, 12'hA10);
    send("R8 x rejected y ok", 12'h900, 12'h310, 12'h410, 12'h310);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      x_i = 12'h123 + 12'(i); y_i = 12'h777 - 12'(i);
    end
    @(negedge clk_i);
    chk("R10 valid idle", valid_o, 0);
    chk("R10 x hold", x_o, 12'h410);
    chk("R10 y hold", y_o, 12'h310);
  endtask

  task automatic t_signed();
    send("R9 far neg rejected", 12'hFF6, 12'h310, 12'h410, 12'h310);
    send("R9 -10 to +10", 12'h00A, 12'h310, 12'h00A, 12'h310);
    send("R9 to 0x7FF rejected", 12'h7FF, 12'h310, 12'h00A, 12'h310);
    send("R9 wrap rejected", 12'h800, 12'h310, 12'h00A, 12'h310);
    send("R9 R7 wrap repeat", 12'h800, 12'h310, 12'h800, 12'h310);
  endtask

  initial begin
    t_reset();
    t_seed();
    t_steps();
    t_idle();
    t_signed();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule